// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the target side of a two-wire serial memory. A fast system clock samples the serial clock and data lines. Each line passes through a synchroniser and a majority vote before edge detection. The engine finds start and stop conditions and decodes the device address byte. It takes a word address, stores data bytes in its byte array, and returns data from an address counter. For read and write acknowledge phases it pulls the data line low through an open-drain enable.

A store can write several bytes in one sequence. The stop that ends a write with at least one stored byte starts a timed write cycle. While that cycle is busy, the engine does not acknowledge its own device address, so a controller can poll until the cycle ends.

In arrays larger than 256 bytes, the upper word-address bits are carried in the device address byte. They replace the same number of strap-compare bits. The block has no streaming interface: its only data path is the serial line, and no back-pressure applies.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset the engine does not drive the data line (`sda_oe` low) until it has to acknowledge or send.
- R2: A device byte is matched when its upper four bits are 1010 and its compare bits equal the matching `strap_addr` bits. With 256 bytes, bits 3..1 are all compared with `strap_addr[2:0]`. On a match the engine drives the ninth clock low (acknowledge). On a mismatch it leaves the line high and ignores all traffic until the next start.
- R3: In a write sequence (device byte with bit 0 = 0), the engine acknowledges the word-address byte and each data byte. It stores each data byte at the current address.
- R4: After any access the address counter holds the last accessed address plus one. A read that starts directly with a device byte whose bit 0 = 1 returns the byte at that address.
- R5: A write sequence that stops after the word address, followed by a repeated start and a read device byte, returns the byte at that word address.
- R6: A controller acknowledge (low) after a read byte makes the engine send the next byte. The read address wraps from the last array byte to byte 0.
- R7: A controller no-acknowledge followed by stop ends the read, and the data line stays released.
- R8: Successive data bytes in one write advance only the low address bits inside a PAGE_BYTES page. After the last byte of a page, the next byte goes to the first byte of the same page.
- R9: After a stop that ends a write with at least one stored byte, the engine does not acknowledge its device address for WR_CYCLES clocks. It acknowledges again after that time.
- R10: With MEM_BYTES = 512, device-byte bit 1 is the word-address bit 8. Only bits 3..2 are compared with `strap_addr[2:1]`.
- R11: The engine changes its data drive only while SCL is low, apart from releasing it at a start or stop. The drive stays constant through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| strap_addr | input | 3 | Hard-wired address straps compared with the device byte |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
Two engines share one bus. One has 256 bytes and straps 000; the other has 512 bytes and straps 111. Each device byte is therefore a hit for at most one of them, which shows that the compare and page bit placement are right. The patterns are:
- Device bytes with a wrong prefix, wrong straps, or a wrong page are used to separate a true match from a loose one.
- Multi-byte writes that cross a page end separate page wrap from a full-address increment.
- A read at the top address followed by an acknowledge separates array wrap from saturation.
- A poll right after a write stop, and another after the cycle time, separate refusal while busy from a refusal that never ends.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACK_DW, S_ACK_DR, S_WADDR, S_ACK_WA,
    S_WDATA, S_ACK_WD, S_RDATA, S_RACK
  } eng_state_t;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   vote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      vote_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      vote_q <= {vote_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= ($countones(vote_q) > (VOTE_TAPS / 2));
    end
  end

  // filtered output only flips toward the newest vote sample
  AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> dout == $past(vote_q[0])) else $error("filter flip"); // R11
endmodule

// File: rtl/twi_eep_array.sv
module twi_eep_array #(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
  assign rdata = mem[addr];
endmodule

// File: rtl/twi_write_timer.sv
module twi_write_timer #(
  parameter int WR_CYCLES = 600,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
  assign busy = (cnt_q != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy) else $error("timer did not start"); // R9
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target #(
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 8,
  parameter int WR_CYCLES   = 600,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_addr,
  output logic       sda_oe
);
  import twi_eep_pkg::*;

  localparam int AW       = $clog2(MEM_BYTES);
  localparam int PAGE_SEL = AW - 8;
  localparam int PB       = $clog2(PAGE_BYTES);
  localparam logic [2:0] CMP_MASK = 3'(3'b111 << PAGE_SEL);

  // line conditioning
  logic [1:0] raw, filt, filt_q;
  assign raw = {scl_in, sda_in};
  for (genvar i = 0; i < 2; i++) begin : g_line
    twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw[i]), .dout(filt[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= 2'b11;
    else        filt_q <= filt;
  end

  logic scl_f, sda_f, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_f     = filt[1];
  assign sda_f     = filt[0];
  assign scl_p     = filt_q[1];
  assign sda_p     = filt_q[0];
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

  // engine state
  eng_state_t    st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, tx_q, rdata;
  logic [AW-1:0] addr_q;
  logic [2:0]    page_q;
  logic          wrote, mack, wr_busy, mem_we, wr_start;
  logic [2:0]    mid_bits, bidx;
  logic          dev_hit;
  logic [10:0]   wide_addr;

  assign mid_bits  = shreg[3:1];
  assign dev_hit   = (shreg[7:4] == DEV_PREFIX) &&
                     (((mid_bits ^ strap_addr) & CMP_MASK) == 3'b000);
  assign wide_addr = {page_q, shreg};
  assign bidx      = 3'(4'd7 - bitcnt);
  assign mem_we    = scl_fall && (st == S_WDATA) && (bitcnt == 4'd8);
  assign wr_start  = stop_det && wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; tx_q <= '0;
      addr_q <= '0; page_q <= '0; sda_oe <= 1'b0; wrote <= 1'b0; mack <= 1'b0;
    end else if (start_det) begin
      st <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0; wrote <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        S_DEV, S_WADDR, S_WDATA: begin
          shreg  <= {shreg[6:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
        S_RDATA: bitcnt <= bitcnt + 1'b1;
        S_RACK:  mack   <= ~sda_f;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_DEV: if (bitcnt == 4'd8) begin
          if (dev_hit && !wr_busy) begin
            sda_oe <= 1'b1;
            if (shreg[0]) st <= S_ACK_DR;
            else begin
              st     <= S_ACK_DW;
              page_q <= mid_bits & ~CMP_MASK;
            end
          end else st <= S_IDLE;
        end
        S_ACK_DW: begin sda_oe <= 1'b0; bitcnt <= '0; st <= S_WADDR; end
        S_WADDR: if (bitcnt == 4'd8) begin
          addr_q <= wide_addr[AW-1:0];
          sda_oe <= 1'b1;
          st     <= S_ACK_WA;
        end
        S_ACK_WA, S_ACK_WD: begin sda_oe <= 1'b0; bitcnt <= '0; st <= S_WDATA; end
        S_WDATA: if (bitcnt == 4'd8) begin
          addr_q <= {addr_q[AW-1:PB], addr_q[PB-1:0] + 1'b1};
          wrote  <= 1'b1;
          sda_oe <= 1'b1;
          st     <= S_ACK_WD;
        end
        S_ACK_DR: begin
          tx_q <= rdata; addr_q <= addr_q + 1'b1;
          sda_oe <= ~rdata[7]; bitcnt <= '0; st <= S_RDATA;
        end
        S_RDATA: begin
          if (bitcnt == 4'd8) begin sda_oe <= 1'b0; st <= S_RACK; end
          else sda_oe <= ~tx_q[bidx];
        end
        S_RACK: begin
          if (mack) begin
            tx_q <= rdata; addr_q <= addr_q + 1'b1;
            sda_oe <= ~rdata[7]; bitcnt <= '0; st <= S_RDATA;
          end else begin
            sda_oe <= 1'b0; st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  twi_eep_array #(.MEM_BYTES(MEM_BYTES)) u_array (
    .clk(clk), .we(mem_we), .addr(addr_q), .wdata(shreg), .rdata(rdata));

  twi_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(wr_busy));

  AST_RESET_RELEASE: assert property (@(posedge clk)
    !rst_n |=> !sda_oe) else $error("drive after reset"); // R1
  AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && st == S_DEV && bitcnt == 4'd8 && wr_busy) |=> !sda_oe)
    else $error("acked while busy"); // R9
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && $past(!start_det && !stop_det)) |-> !scl_f)
    else $error("drive changed with SCL high"); // R11
  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> addr_q[AW-1:PB] == $past(addr_q[AW-1:PB]))
    else $error("write left its page"); // R8
  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && st == S_ACK_DR) |=> addr_q == AW'($past(addr_q) + 1'b1))
    else $error("read counter stuck"); // R6
endmodule

// File: tb/sim_twi_eeprom_target.sv
module sim_twi_eeprom_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic oe0, oe1, line;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  assign line = msda & ~oe0 & ~oe1;

  twi_eeprom_target #(.MEM_BYTES(256), .PAGE_BYTES(8), .WR_CYCLES(600)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line),
    .strap_addr(3'b000), .sda_oe(oe0));
  twi_eeprom_target #(.MEM_BYTES(512), .PAGE_BYTES(16), .WR_CYCLES(600)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line),
    .strap_addr(3'b111), .sda_oe(oe1));

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      exp_q[$];
  event       obs_ev;
  logic [7:0] obs_v;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(logic [7:0] v, string tag);
    item_t it;
    it.v = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compares every observed item against the scoreboard queue
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) chk(1'b0, "unexpected item", int'(obs_v), 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(obs_v === it.v, it.tag, int'(obs_v), int'(it.v));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    msda = 1'b0; tick(Q); scl = 1'b1; tick(Q); msda = 1'b1; tick(Q);
  endtask

  task automatic clock_bit(logic b, output logic smp_a, output logic smp_b);
    msda = b; tick(Q); scl = 1'b1; tick(2);
    smp_a = line; tick(2*Q-4);
    smp_b = line; tick(2); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b);
    logic a, c;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], a, c);
    clock_bit(1'b1, a, c);
    chk(a === c, "R11 ack level held through SCL high", int'(c), int'(a));
    obs_v = {7'b0, c};
    -> obs_ev;
  endtask

  task automatic read_byte(logic m_ack);
    logic a, c;
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, a, c);
      r[i] = c;
    end
    clock_bit(~m_ack, a, c);
    msda = 1'b1;
    obs_v = r;
    -> obs_ev;
  endtask

  task automatic write_seq(logic [7:0] dev, logic [7:0] wa, logic [7:0] d [], string tag);
    do_start();
    expect_item(8'h00, {tag, " dev ack"}); send_byte(dev);
    expect_item(8'h00, {tag, " addr ack"}); send_byte(wa);
    foreach (d[k]) begin
      expect_item(8'h00, {tag, " data ack"}); send_byte(d[k]);
    end
    do_stop();
  endtask

  task automatic rand_read(logic [7:0] dev, logic [7:0] wa, logic [7:0] e [], string tag);
    do_start();
    expect_item(8'h00, {tag, " dev ack"}); send_byte(dev);
    expect_item(8'h00, {tag, " addr ack"}); send_byte(wa);
    do_start();
    expect_item(8'h00, {tag, " read dev ack"}); send_byte(dev | 8'h01);
    foreach (e[k]) begin
      expect_item(e[k], {tag, " read data"});
      read_byte(k != e.size() - 1);
    end
    do_stop();
  endtask

  initial begin
    tick(5);
    chk(oe0 === 1'b0, "R1 u0 released in reset", int'(oe0), 0);
    rst_n = 1'b1;
    tick(10);
    chk(oe0 === 1'b0 && oe1 === 1'b0, "R1 released after reset", int'({oe1, oe0}), 0);

    // R2 strap mismatch, then ignored byte; wrong prefix
    do_start();
    expect_item(8'h01, "R2 strap mismatch nack"); send_byte(8'hA6);
    expect_item(8'h01, "R2 ignored after mismatch"); send_byte(8'h00);
    do_stop();
    do_start();
    expect_item(8'h01, "R2 prefix mismatch nack"); send_byte(8'hB0);
    do_stop();

    // R3 multi-byte write
    write_seq(8'hA0, 8'h10, '{8'h11, 8'h22, 8'h33}, "R3");
    // R9 poll during the write cycle, then after it
    do_start();
    expect_item(8'h01, "R9 nack while busy"); send_byte(8'hA0);
    do_stop();
    tick(700);
    do_start();
    expect_item(8'h00, "R9 ack after cycle"); send_byte(8'hA0);
    do_stop();

    // R5 random read, R4 current-address read
    rand_read(8'hA0, 8'h10, '{8'h11}, "R5");
    do_start();
    expect_item(8'h00, "R4 dev ack"); send_byte(8'hA1);
    expect_item(8'h22, "R4 current address data"); read_byte(1'b0);
    do_stop();

    // R8 page wrap inside an 8-byte page
    write_seq(8'hA0, 8'h26, '{8'hA1, 8'hA2, 8'hA3}, "R8");
    tick(700);
    rand_read(8'hA0, 8'h26, '{8'hA1, 8'hA2}, "R8");
    rand_read(8'hA0, 8'h20, '{8'hA3}, "R8 wrapped byte");

    // R6 array wrap on sequential read
    write_seq(8'hA0, 8'hFF, '{8'hAA}, "R6");
    tick(700);
    write_seq(8'hA0, 8'h00, '{8'h55}, "R6");
    tick(700);
    rand_read(8'hA0, 8'hFF, '{8'hAA, 8'h55}, "R6");

    // R7 line stays released after nack + stop
    tick(20);
    chk(line === 1'b1 && oe0 === 1'b0, "R7 released after read end", int'(line), 1);

    // R10 page bit carried in device byte (u1, 512 bytes)
    write_seq(8'hAE, 8'h05, '{8'hC3}, "R10");
    tick(700);
    write_seq(8'hAC, 8'h05, '{8'h3C}, "R10");
    tick(700);
    rand_read(8'hAE, 8'h05, '{8'hC3}, "R10 page1");
    rand_read(8'hAC, 8'h05, '{8'h3C}, "R10 page0");
    do_start();
    expect_item(8'h01, "R10 strap mismatch nack"); send_byte(8'hA6);
    do_stop();

    tick(50);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule